// File: doc/BRIEF.md
# EEPROM Page Write Buffer Unit

This block is the storage side of a two-wire serial EEPROM slave. A bus controller, which handles framing and acknowledge, drives it through single-cycle strobes. The strobes load a memory address, hand over one received data byte, step the read pointer, or signal the stop condition that closes a write. The block keeps the current address and stages incoming bytes in a one-page buffer. After a stop it copies the staged bytes into a behavioural memory array during a timed busy window. The controller reads `busy_o` to answer acknowledge polling.

Write data wraps inside a 64-byte page, so a byte sent after the last page location lands back at the page start and replaces what was staged there. Read stepping runs across the whole array and wraps from the top address to zero. When write protection is asserted, the top eighth of the array cannot be written. Reads are never blocked. During the busy window every strobe from the controller is ignored. The array size is a parameter: 15 address bits gives the full part, and the default is kept small. `BUSY_CYCLES` must be at least one page long.

Top module: `eeprom_page_stager`

## Requirements
- R1: After reset `busy_o` is low.
- R2: A load strobe sets `cur_addr_o` to `addr_i` on the next clock edge.
- R3: Each accepted data byte advances only the low six bits of the current address. The upper bits keep the page, so location 63 of a page is followed by location 0 of the same page.
- R4: When more than 64 bytes are sent in one write, the later byte for a page location replaces the earlier one, and only the final value reaches the array.
- R5: At commit, only page locations that received a byte since the last address load are written. All other locations of the page keep their contents.
- R6: A stop with at least one staged byte raises `busy_o` on the next edge and holds it high for exactly `BUSY_CYCLES` clock cycles. A stop with nothing staged leaves `busy_o` low.
- R7: While `busy_o` is high, load, data, read-advance and stop strobes have no effect. The current address does not move, no byte is staged, and no new busy window follows.
- R8: With `wp_i` high, a byte whose current address has its three top address bits all ones is not staged, and the following stop starts no busy window. With `wp_i` low those addresses are written normally, and pages outside the top eighth are writable whatever the level of `wp_i`.
- R9: A read-advance strobe adds one to the full current address, wrapping from all ones to zero. `rd_data_o` shows the array byte at the address held during the previous cycle.
- R10: A load strobe discards every byte staged since the previous load, so a stop that follows commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_addr_i | input | 1 | Load `addr_i` as the current address and drop staged bytes |
| addr_i | input | ADDR_W | Address to load |
| wr_byte_i | input | 1 | One received write byte is present on `wr_data_i` |
| wr_data_i | input | 8 | Write byte |
| rd_adv_i | input | 1 | Step the current address after a byte has been read |
| stop_i | input | 1 | Stop condition seen after write data |
| wp_i | input | 1 | Write protection of the top eighth of the array |
| rd_data_o | output | 8 | Array byte at the current address, one cycle late |
| cur_addr_o | output | ADDR_W | Current address |
| busy_o | output | 1 | Commit window in progress |

## Verification
The first pass fills every page with 64 bytes, each page starting at a different in-page offset. A following read walks the entire array through the read-advance strobe and wraps to zero. This shows the in-page wrap of writes apart from the whole-array wrap of reads. Short writes that straddle the page end, and writes longer than a page, show whether the valid bits leave untouched locations alone and whether the last byte wins. The tail of the run checks protection with and without `wp_i` on both a guarded and an unguarded page. It then confirms that staged bytes are dropped on a reload and that strobes sent during the busy window change nothing visible at the ports.

// File: rtl/pw_pkg.sv
package pw_pkg;
    // one storage word of the array
    localparam int unsigned BYTE_W     = 8;
    // address top bits that select the guarded region (one eighth)
    localparam int unsigned PROT_SEL_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pw_addr_ctr.sv
module pw_addr_ctr #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] AD_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.addr = load_addr;
        end else if (wr_step) begin
            // write stepping stays inside the page
            ctr_d.addr = {ctr_q.addr[ADDR_W-1:PAGE_W], ctr_q.addr[PAGE_W-1:0] + PG_ONE};
        end else if (rd_step) begin
            ctr_d.addr = ctr_q.addr + AD_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cur_addr = ctr_q.addr;

    // R3: a write step never leaves the page
    assert_page_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load) |=> (cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])));

    // R9: a read step adds one over the whole address
    assert_read_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !load && !wr_step) |=> (cur_addr == $past(cur_addr) + AD_ONE));

    // R2: a load takes the presented address
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(load_addr)));
endmodule

// File: rtl/pw_stage_buf.sv
module pw_stage_buf
    import pw_pkg::*;
#(
    parameter int unsigned PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stage_en,
    input  logic [PAGE_W-1:0] stage_idx,
    input  byte_t             stage_data,
    input  logic [PAGE_W-1:0] pick_idx,
    output byte_t             pick_data,
    output logic              pick_vld,
    output logic              any_vld
);
    localparam int unsigned PAGES = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGES-1:0][BYTE_W-1:0] data;
        logic [PAGES-1:0]             vld;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear) begin
            buf_d.vld = '0;
        end else if (stage_en) begin
            buf_d.data[stage_idx] = stage_data;
            buf_d.vld[stage_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign pick_data = buf_q.data[pick_idx];
    assign pick_vld  = buf_q.vld[pick_idx];
    assign any_vld   = |buf_q.vld;

    // R10: a clear leaves nothing staged
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_vld);

    // R4: a staged byte is held at its slot
    assert_stage_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en && !clear) |=> (buf_q.vld[$past(stage_idx)] && buf_q.data[$past(stage_idx)] == $past(stage_data)));
endmodule

// File: rtl/pw_busy_timer.sv
module pw_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 80,
    parameter int unsigned PAGE_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);
    // BUSY_CYCLES must cover one page so that every slot gets a commit cycle
    localparam int unsigned     CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(BUSY_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_LIM  = CNT_W'(1 << PAGE_W);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] elapsed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done = tmr_q.run && (tmr_q.elapsed == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.run) begin
            if (start) begin
                tmr_d.run     = 1'b1;
                tmr_d.elapsed = '0;
            end
        end else if (done) begin
            tmr_d.run = 1'b0;
        end else begin
            tmr_d.elapsed = tmr_q.elapsed + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy       = tmr_q.run;
    assign commit_en  = tmr_q.run && (tmr_q.elapsed < PG_LIM);
    assign commit_idx = tmr_q.elapsed[PAGE_W-1:0];

    // R6: a start from idle opens the window at count zero
    assert_start_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && tmr_q.elapsed == '0));

    // R6: the window holds until its last cycle
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: the window closes right after its last cycle
    assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/eeprom_page_stager.sv
module eeprom_page_stager
    import pw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned PAGE_W      = 6,
    parameter int unsigned BUSY_CYCLES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_byte_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_adv_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic [7:0]        rd_data_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              busy_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic              busy, done, commit_en, commit_vld, any_vld;
    logic [PAGE_W-1:0] commit_idx;
    byte_t             commit_data;
    logic [ADDR_W-1:0] cur_addr;

    // strobes accepted only outside the busy window
    logic take_ld, take_wr, take_rd, take_stop, guarded, stage_en, start, clear;

    assign take_ld   = ld_addr_i && !busy;
    assign take_wr   = wr_byte_i && !busy && !take_ld;
    assign take_rd   = rd_adv_i  && !busy;
    assign take_stop = stop_i    && !busy;
    assign guarded   = wp_i && (&cur_addr[ADDR_W-1 -: PROT_SEL_W]);
    assign stage_en  = take_wr && !guarded;
    assign start     = take_stop && any_vld;
    assign clear     = take_ld || done;

    pw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_ld),
        .load_addr (addr_i),
        .wr_step   (take_wr),
        .rd_step   (take_rd),
        .cur_addr  (cur_addr)
    );

    pw_stage_buf #(.PAGE_W(PAGE_W)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .stage_en   (stage_en),
        .stage_idx  (cur_addr[PAGE_W-1:0]),
        .stage_data (wr_data_i),
        .pick_idx   (commit_idx),
        .pick_data  (commit_data),
        .pick_vld   (commit_vld),
        .any_vld    (any_vld)
    );

    pw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) i_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .commit_en  (commit_en),
        .commit_idx (commit_idx)
    );

    // behavioural array: one slot committed per busy cycle, registered read
    byte_t mem [DEPTH];
    byte_t rd_q;

    always_ff @(posedge clk) begin
        if (commit_en && commit_vld) begin
            mem[{cur_addr[ADDR_W-1:PAGE_W], commit_idx}] <= commit_data;
        end
        rd_q <= mem[cur_addr];
    end

    assign rd_data_o  = rd_q;
    assign cur_addr_o = cur_addr;
    assign busy_o     = busy;

    // R7: the address is frozen while busy
    assert_frozen_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cur_addr_o));

    // R6: a stop with nothing staged starts no window
    assert_empty_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !any_vld) |=> !busy_o);

    // R8: a guarded byte onto an empty buffer leaves it empty
    assert_guarded_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && wp_i && (&cur_addr_o[ADDR_W-1 -: PROT_SEL_W]) && !busy_o && !any_vld) |=> !any_vld);
endmodule

// File: tb/test_eeprom_page_stager.sv
module test_eeprom_page_stager;
    localparam int AW    = 10;
    localparam int PW    = 6;
    localparam int BUSY  = 80;
    localparam int PG    = 1 << PW;
    localparam int DEPTH = 1 << AW;
    localparam int NPG   = DEPTH / PG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_addr_i = 1'b0, wr_byte_i = 1'b0, rd_adv_i = 1'b0, stop_i = 1'b0, wp_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    wr_data_i = '0;
    logic [7:0]    rd_data_o;
    logic [AW-1:0] cur_addr_o;
    logic          busy_o;

    always #2.5 clk = ~clk;

    eeprom_page_stager #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY)) i_eeprom_page_stager (
        .clk(clk), .rst_n(rst_n), .ld_addr_i(ld_addr_i), .addr_i(addr_i),
        .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i), .rd_adv_i(rd_adv_i),
        .stop_i(stop_i), .wp_i(wp_i), .rd_data_o(rd_data_o),
        .cur_addr_o(cur_addr_o), .busy_o(busy_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int ref_mem [DEPTH];

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input int a);
        ld_addr_i = 1'b1; addr_i = AW'(a); tick(); ld_addr_i = 1'b0;
    endtask

    task automatic put_byte(input int d);
        wr_byte_i = 1'b1; wr_data_i = 8'(d); tick(); wr_byte_i = 1'b0;
    endtask

    task automatic send_stop();
        stop_i = 1'b1; tick(); stop_i = 1'b0;
    endtask

    task automatic advance();
        rd_adv_i = 1'b1; tick(); rd_adv_i = 1'b0;
    endtask

    // counts busy cycles seen at negedges, starting with the current one
    task automatic wait_busy(output int cnt);
        cnt = 0;
        while (busy_o && cnt < 4 * BUSY) begin
            cnt++;
            tick();
        end
    endtask

    // load, send n bytes from in-page offset off, then stop; updates the model
    task automatic write_run(input int pg, input int off, input int n, input int seed, input bit keep);
        load(pg * PG + off);
        for (int k = 0; k < n; k++) begin
            int a = pg * PG + ((off + k) % PG);
            int d = (seed + k * 13) & 8'hFF;
            put_byte(d);
            if (keep) ref_mem[a] = d;
        end
        send_stop();
    endtask

    task automatic read_chk(input string req, input int a);
        load(a);
        tick();
        chk(req, rd_data_o, ref_mem[a] & 8'hFF);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 busy after reset", busy_o, 0);

        // fill every page, each from a different start offset (R3, R6, wp low side of R8)
        for (int p = 0; p < NPG; p++) begin
            int off = (p * 5 + 3) % PG;
            write_run(p, off, PG, p * 17 + 3, 1'b1);
            chk("R3 in-page wrap of address", cur_addr_o, p * PG + off);
            wait_busy(cnt);
            chk("R6 busy length", cnt, BUSY);
        end

        // whole-array walk through read-advance (R9, R2)
        load(0);
        chk("R2 load address", cur_addr_o, 0);
        tick();
        for (int a = 0; a < DEPTH; a++) begin
            chk("R9 sequential read data", rd_data_o, ref_mem[a]);
            advance();
            tick();
        end
        chk("R9 wrap to zero", cur_addr_o, 0);

        // short run across the page end (R5)
        write_run(2, 60, 6, 8'h55, 1'b1);
        chk("R3 wrap after page end", cur_addr_o, 2 * PG + 2);
        wait_busy(cnt);
        for (int o = 0; o < PG; o++) read_chk("R5 untouched slots kept", 2 * PG + o);

        // longer than a page: last byte wins (R4)
        write_run(3, 0, PG + 6, 8'h21, 1'b1);
        wait_busy(cnt);
        chk("R4 busy length", cnt, BUSY);
        for (int o = 0; o < PG; o++) read_chk("R4 overwritten slots", 3 * PG + o);

        // protection (R8): top eighth guarded, page 5 not
        wp_i = 1'b1;
        write_run(14, 4, 3, 8'h90, 1'b0);
        chk("R8 guarded stop starts no busy", busy_o, 0);
        for (int o = 4; o < 7; o++) read_chk("R8 guarded data unchanged", 14 * PG + o);
        write_run(5, 10, 4, 8'h33, 1'b1);
        wait_busy(cnt);
        chk("R8 unguarded page busy", cnt, BUSY);
        for (int o = 10; o < 14; o++) read_chk("R8 unguarded page written", 5 * PG + o);
        wp_i = 1'b0;
        write_run(15, 60, 2, 8'h7E, 1'b1);
        wait_busy(cnt);
        read_chk("R8 wp low top region", 15 * PG + 60);
        read_chk("R8 wp low top region", 15 * PG + 61);

        // reload discards staged bytes (R10), empty stop (R6)
        load(400);
        put_byte(8'hAA);
        load(400);
        send_stop();
        chk("R10 reload drops staged", busy_o, 0);
        read_chk("R10 data unchanged", 400);
        load(10);
        send_stop();
        chk("R6 empty stop", busy_o, 0);

        // strobes during busy are ignored (R7)
        write_run(9, 24, 2, 8'hC4, 1'b1);
        load(5);
        advance();
        put_byte(8'h11);
        send_stop();
        chk("R7 address frozen", cur_addr_o, 9 * PG + 26);
        wait_busy(cnt);
        chk("R7 window not restarted", cnt, BUSY - 4);
        send_stop();
        chk("R7 busy byte not staged", busy_o, 0);
        for (int o = 24; o < 27; o++) read_chk("R7 contents", 9 * PG + o);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule